// File: doc/BRIEF.md
# Temperature Sensor Status Capture

This block sits between an on-die temperature sensor converter and a read-only status register. The sensor signals each finished conversion with a valid pulse that lasts only a few clock cycles. The block passes that pulse through a synchronizer and detects its rising edge. On that edge it captures the 10-bit temperature code. It keeps a latched copy of the valid level and a flag that records the first conversion. It also evaluates four alerts against programmed limits: two high thresholds, one low threshold and a maximum-temperature limit.

Everything is presented as one 32-bit status word that software reads. Each field has its own clear scope. A power-on reset clears every field. A synchronous soft clear wipes the flags and leaves the temperature code in place. Leaving continuous mode drops the first-conversion flag and the threshold alerts. The maximum-temperature alert is not sticky: it follows the current code.

Top module: `tsense_stat_capture`

## Requirements
- R1: While and after the asynchronous active-low power-on reset, and before any conversion, bits 15:0 of `statusWord` read zero.
- R2: The code present on `sensCode` is captured into `statusWord[9:0]` after the third rising clock edge at which `sensValid` is high. That is two synchronizer stages plus one capture register. The code then holds until the next conversion.
- R3: `statusWord[10]` is a latched copy of the synchronized valid level. It is still 0 after the second edge with `sensValid` high and is 1 after the third. It returns to 0 three edges after `sensValid` falls.
- R4: `statusWord[11]` is set together with the captured code when `contMode` is 1. It stays set across later conversions. It is cleared by a soft clear or by `contMode` at 0, and it is not set by a conversion while `contMode` is 0.
- R5: One clock edge with `softClrN` low clears bits 14:10 and leaves the code in bits 9:0 unchanged.
- R6: One edge after a new code appears, the threshold alerts update as unsigned comparisons. Bit 12 is `code > limHigh1`. Bit 13 is `code > limHigh2`. Bit 14 is `code < limLow`. Each alert is gated by its own enable input and needs `contMode` at 1.
- R7: While `contMode` is 0, bits 14:12 read 0, including after conversions made in that state.
- R8: `statusWord[15]` equals `enMax && code > limMax`, one edge after the code or the limit changes. It is not sticky, and a soft clear does not affect it.
- R9: `statusWord[19:16]` equals `vdomTie`, and bits 31:20 read 0.
- R10: A code equal to a limit raises none of the four alerts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porRstN | input | 1 | Asynchronous active-low power-on reset |
| softClrN | input | 1 | Synchronous active-low soft clear of the flags |
| contMode | input | 1 | Continuous-mode enable |
| sensValid | input | 1 | Sensor end-of-conversion pulse (asynchronous) |
| sensCode | input | 10 | Sensor temperature code, stable while the pulse is high |
| enHigh1 | input | 1 | Enable of the first high-threshold alert |
| enHigh2 | input | 1 | Enable of the second high-threshold alert |
| enLow | input | 1 | Enable of the low-threshold alert |
| enMax | input | 1 | Enable of the maximum-temperature alert |
| limHigh1 | input | 10 | First high threshold |
| limHigh2 | input | 10 | Second high threshold |
| limLow | input | 10 | Low threshold |
| limMax | input | 10 | Maximum-temperature limit |
| vdomTie | input | 4 | Voltage-domain tie-off value |
| statusWord | output | 32 | Read-only status word |

## Verification
The bench builds the block with its default parameters: a 10-bit code, a 4-bit domain field, a 32-bit word and a two-stage synchronizer. With the 10-bit code it can drive conversions at both ends of the range, 0 and 1023. It also sets codes exactly equal to each limit, so the strict comparisons are checked at their boundary. The two-stage synchronizer fixes the latency, so the bench can sample the valid bit one edge before and one edge after it is expected to rise.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  // Strobes from the control side to the datapath, all valid for one cycle.
  typedef struct packed {
    logic capture;    // synchronized rising edge of the sensor pulse
    logic validUpd;   // synchronized pulse level changed
    logic validNext;  // synchronized pulse level
    logic firstSet;   // set the first-conversion flag
    logic firstClr;   // drop first flag and threshold alerts
    logic flagClr;    // soft clear of the valid bit
    logic evalAlerts; // compare the freshly captured code
  } ctlStrobe_t;
endpackage

// File: rtl/tsense_ctl.sv
module tsense_ctl
  import tsense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       softClrN,
  input  logic       contMode,
  input  logic       sensValid,
  output ctlStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic evalQ;
  logic rise;
  logic toggle;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) syncQ <= '0;
        else          syncQ <= {syncQ[SYNC_STAGES-2:0], sensValid};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) syncQ <= '0;
        else          syncQ <= sensValid;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      prevQ <= 1'b0;
      evalQ <= 1'b0;
    end else begin
      prevQ <= syncQ[LAST];
      evalQ <= rise;
    end
  end

  assign rise   = syncQ[LAST] & ~prevQ;
  assign toggle = syncQ[LAST] ^ prevQ;

  always_comb begin
    strobe            = '0;
    strobe.capture    = rise;
    strobe.validUpd   = toggle;
    strobe.validNext  = syncQ[LAST];
    strobe.firstSet   = rise & contMode;
    strobe.firstClr   = ~softClrN | ~contMode;
    strobe.flagClr    = ~softClrN;
    strobe.evalAlerts = evalQ;
  end

  // R2
  capture_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.capture |=> !strobe.capture);

  // R2
  eval_follows_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.evalAlerts |-> !strobe.capture);
endmodule

// File: rtl/tsense_dp.sv
module tsense_dp
  import tsense_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int VDOM_W = 4,
  parameter int WORD_W = 32,
  parameter int N_THR  = 3,
  parameter logic [N_THR-1:0] THR_BELOW = 3'b100
) (
  input  logic                          clk,
  input  logic                          porRstN,
  input  ctlStrobe_t                    strobe,
  input  logic [CODE_W-1:0]             sensCode,
  input  logic [N_THR-1:0]              thrEn,
  input  logic [N_THR-1:0][CODE_W-1:0]  thrLim,
  input  logic                          enMax,
  input  logic [CODE_W-1:0]             limMax,
  input  logic [VDOM_W-1:0]             vdomTie,
  output logic [WORD_W-1:0]             statusWord
);
  localparam int VALID_POS = CODE_W;
  localparam int FIRST_POS = CODE_W + 1;
  localparam int ALERT_POS = CODE_W + 2;
  localparam int MAX_POS   = ALERT_POS + N_THR;
  localparam int VDOM_POS  = MAX_POS + 1;

  logic [CODE_W-1:0] codeReg;
  logic              validBit;
  logic              firstFlag;
  logic [N_THR-1:0]  alertQ;
  logic [N_THR-1:0]  hitVec;
  logic              maxAlert;

  // Code: power-on reset only.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            codeReg <= '0;
    else if (strobe.capture) codeReg <= sensCode;
  end

  // Valid copy and first-conversion flag.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      validBit  <= 1'b0;
      firstFlag <= 1'b0;
    end else begin
      if (strobe.flagClr)       validBit <= 1'b0;
      else if (strobe.validUpd) validBit <= strobe.validNext;

      if (strobe.firstClr)      firstFlag <= 1'b0;
      else if (strobe.firstSet) firstFlag <= 1'b1;
    end
  end

  // One comparator per threshold; direction chosen by parameter.
  generate
    for (genvar i = 0; i < N_THR; i++) begin : g_thr
      if (THR_BELOW[i]) begin : g_lo
        assign hitVec[i] = codeReg < thrLim[i];
      end else begin : g_hi
        assign hitVec[i] = codeReg > thrLim[i];
      end

      // R6
      thr_en_chk: assert property (@(posedge clk) disable iff (!porRstN)
        !thrEn[i] |=> !alertQ[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      alertQ <= '0;
    end else begin
      for (int i = 0; i < N_THR; i++) begin
        if (strobe.firstClr || !thrEn[i]) alertQ[i] <= 1'b0;
        else if (strobe.evalAlerts)       alertQ[i] <= hitVec[i];
      end
    end
  end

  // Max alert: tracks the current code, no soft clear.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) maxAlert <= 1'b0;
    else          maxAlert <= enMax && (codeReg > limMax);
  end

  always_comb begin
    statusWord                              = '0;
    statusWord[CODE_W-1:0]                  = codeReg;
    statusWord[VALID_POS]                   = validBit;
    statusWord[FIRST_POS]                   = firstFlag;
    statusWord[ALERT_POS +: N_THR]          = alertQ;
    statusWord[MAX_POS]                     = maxAlert;
    statusWord[VDOM_POS +: VDOM_W]          = vdomTie;
  end

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !strobe.capture |=> $stable(codeReg));

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.flagClr |=> (!validBit && !firstFlag && alertQ == '0));

  // R4
  first_clr_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.firstClr |=> !firstFlag);

  // R4
  first_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strobe.firstSet && !strobe.firstClr) |=> firstFlag);

  // R7
  alerts_off_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.firstClr |=> (alertQ == '0));

  // R8
  max_en_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !enMax |=> !maxAlert);
endmodule

// File: rtl/tsense_stat_capture.sv
module tsense_stat_capture
  import tsense_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int VDOM_W      = 4,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softClrN,
  input  logic              contMode,
  input  logic              sensValid,
  input  logic [CODE_W-1:0] sensCode,
  input  logic              enHigh1,
  input  logic              enHigh2,
  input  logic              enLow,
  input  logic              enMax,
  input  logic [CODE_W-1:0] limHigh1,
  input  logic [CODE_W-1:0] limHigh2,
  input  logic [CODE_W-1:0] limLow,
  input  logic [CODE_W-1:0] limMax,
  input  logic [VDOM_W-1:0] vdomTie,
  output logic [WORD_W-1:0] statusWord
);
  localparam int N_THR = 3;
  // Threshold order sets the alert bit order: high1, high2, low.
  localparam logic [N_THR-1:0] THR_BELOW = 3'b100;

  ctlStrobe_t                   strobe;
  logic [N_THR-1:0]             thrEn;
  logic [N_THR-1:0][CODE_W-1:0] thrLim;

  assign thrEn  = {enLow, enHigh2, enHigh1};
  assign thrLim = {limLow, limHigh2, limHigh1};

  tsense_ctl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .clk       (clk),
    .porRstN   (porRstN),
    .softClrN  (softClrN),
    .contMode  (contMode),
    .sensValid (sensValid),
    .strobe    (strobe)
  );

  tsense_dp #(
    .CODE_W    (CODE_W),
    .VDOM_W    (VDOM_W),
    .WORD_W    (WORD_W),
    .N_THR     (N_THR),
    .THR_BELOW (THR_BELOW)
  ) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .strobe     (strobe),
    .sensCode   (sensCode),
    .thrEn      (thrEn),
    .thrLim     (thrLim),
    .enMax      (enMax),
    .limMax     (limMax),
    .vdomTie    (vdomTie),
    .statusWord (statusWord)
  );
endmodule

// File: tb/sim_tsense_stat_capture.sv
module sim_tsense_stat_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        softClrN = 1'b1;
  logic        contMode = 1'b1;
  logic        sensValid = 1'b0;
  logic [9:0]  sensCode = '0;
  logic        enHigh1 = 1'b1, enHigh2 = 1'b1, enLow = 1'b1, enMax = 1'b1;
  logic [9:0]  limHigh1 = 10'd600, limHigh2 = 10'd800, limLow = 10'd200, limMax = 10'd900;
  logic [3:0]  vdomTie = 4'h5;
  logic [31:0] statusWord;

  int total = 0;
  int bad = 0;
  logic [31:0] midWord, alertWord, endWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsense_stat_capture u0 (
    .clk(clk), .porRstN(porRstN), .softClrN(softClrN), .contMode(contMode),
    .sensValid(sensValid), .sensCode(sensCode),
    .enHigh1(enHigh1), .enHigh2(enHigh2), .enLow(enLow), .enMax(enMax),
    .limHigh1(limHigh1), .limHigh2(limHigh2), .limLow(limLow), .limMax(limMax),
    .vdomTie(vdomTie), .statusWord(statusWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One conversion: pulse high for four edges, then low until settled.
  task automatic conv(input logic [9:0] c);
    @(negedge clk);
    sensCode  = c;
    sensValid = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 valid not yet", {31'd0, statusWord[10]}, 32'd0);
    @(posedge clk); @(negedge clk);
    midWord = statusWord;
    @(posedge clk); @(negedge clk);
    alertWord = statusWord;
    sensValid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    endWord = statusWord;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 during reset", statusWord, 32'h0005_0000);
    porRstN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 after reset", {16'd0, statusWord[15:0]}, 32'd0);
    chk("R9 domain and upper", {statusWord[31:16], 16'd0}, 32'h0005_0000);
  endtask

  task automatic t_capture;
    conv(10'd500);
    chk("R2 code", {22'd0, midWord[9:0]}, 32'd500);
    chk("R3 valid high", {31'd0, midWord[10]}, 32'd1);
    chk("R4 first set", {31'd0, midWord[11]}, 32'd1);
    chk("R6 no alerts", {28'd0, alertWord[15:12]}, 32'd0);
    chk("R3 valid low", {31'd0, endWord[10]}, 32'd0);
    chk("R2 code held", {22'd0, endWord[9:0]}, 32'd500);
    conv(10'd300);
    chk("R4 first stays", {31'd0, midWord[11]}, 32'd1);
  endtask

  task automatic t_thresholds;
    conv(10'd700);
    chk("R6 high1", {28'd0, alertWord[15:12]}, 32'b0001);
    conv(10'd850);
    chk("R6 high1+high2", {28'd0, alertWord[15:12]}, 32'b0011);
    conv(10'd100);
    chk("R6 low", {28'd0, alertWord[15:12]}, 32'b0100);
    conv(10'd950);
    chk("R8 max with highs", {28'd0, alertWord[15:12]}, 32'b1011);
    conv(10'd1023);
    chk("R8 top code", {28'd0, alertWord[15:12]}, 32'b1011);
    conv(10'd0);
    chk("R6 bottom code", {28'd0, alertWord[15:12]}, 32'b0100);
    enHigh1 = 1'b0;
    conv(10'd700);
    chk("R6 enable off", {28'd0, alertWord[15:12]}, 32'b0000);
    enHigh1 = 1'b1;
  endtask

  task automatic t_boundary;
    conv(10'd600);
    chk("R10 equal high1", {28'd0, alertWord[15:12]}, 32'b0000);
    conv(10'd800);
    chk("R10 equal high2", {28'd0, alertWord[15:12]}, 32'b0001);
    conv(10'd200);
    chk("R10 equal low", {28'd0, alertWord[15:12]}, 32'b0000);
    conv(10'd900);
    chk("R10 equal max", {28'd0, alertWord[15:12]}, 32'b0011);
  endtask

  task automatic t_softclr;
    conv(10'd950);
    @(negedge clk);
    softClrN = 1'b0;
    @(posedge clk); @(negedge clk);
    softClrN = 1'b1;
    chk("R5 flags cleared", {27'd0, statusWord[14:10]}, 32'd0);
    chk("R5 code kept", {22'd0, statusWord[9:0]}, 32'd950);
    chk("R8 max survives clear", {31'd0, statusWord[15]}, 32'd1);
    conv(10'd300);
    chk("R4 first after clear", {31'd0, midWord[11]}, 32'd1);
  endtask

  task automatic t_contmode;
    conv(10'd850);
    @(negedge clk);
    contMode = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R4 first drops", {31'd0, statusWord[11]}, 32'd0);
    chk("R7 alerts drop", {29'd0, statusWord[14:12]}, 32'd0);
    conv(10'd950);
    chk("R2 code off mode", {22'd0, midWord[9:0]}, 32'd950);
    chk("R4 no set off mode", {31'd0, midWord[11]}, 32'd0);
    chk("R7 no alerts off mode", {29'd0, alertWord[14:12]}, 32'd0);
    chk("R8 max off mode", {31'd0, alertWord[15]}, 32'd1);
    @(negedge clk);
    contMode = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 no set on mode return", {31'd0, statusWord[11]}, 32'd0);
    conv(10'd100);
    chk("R6 low after return", {28'd0, alertWord[15:12]}, 32'b0100);
    chk("R4 set after return", {31'd0, alertWord[11]}, 32'd1);
  endtask

  task automatic t_maxtrack;
    conv(10'd950);
    chk("R8 max set", {31'd0, alertWord[15]}, 32'd1);
    @(negedge clk);
    limMax = 10'd1000;
    @(posedge clk); @(negedge clk);
    chk("R8 max not sticky", {31'd0, statusWord[15]}, 32'd0);
    limMax = 10'd900;
    @(posedge clk); @(negedge clk);
    chk("R8 max back", {31'd0, statusWord[15]}, 32'd1);
    enMax = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 max disabled", {31'd0, statusWord[15]}, 32'd0);
    enMax = 1'b1;
    chk("R9 domain steady", {statusWord[31:16], 16'd0}, 32'h0005_0000);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_capture();
    t_thresholds();
    t_boundary();
    t_softclr();
    t_contmode();
    t_maxtrack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule